// File: doc/BRIEF.md
# Periodic Down-Counting Timer with Compare Interrupt

The block is a 32-bit down-counter driven by one of three tick-enable inputs, divided by a programmable prescaler. When the count reaches zero it either reloads from a software-set load value or wraps to all ones. When a prescaled tick moves the count onto a software-set compare value, a sticky status flag is set. That flag drives a level interrupt, gated by an interrupt-enable bit and the run bit.

Software reaches five word registers through a small request bus: control at offset 0, status at 1, load at 2, compare at 3 and a read-only live count at 4. The request channel is valid/ready. `bus_ready` is held high, so there is no back-pressure, and one access is accepted on every cycle where `bus_valid` is high. A read request answers on the next cycle with `rd_valid` and `rd_data`. The response cannot be stalled, so the requester must take it in that cycle.

Control bit layout: run=0, restart-on-run=1, compare-interrupt-enable=2, use-load=3, prescale=15:4, soft-reset=16, load-overwrite=17, hold bits 21:18, clock source=25:24. The tick inputs are single-cycle enables that are synchronous to `clk`.

Top module: `pit_timer`

## Requirements
- R1: A read at offset 0 to 4 returns control, status ({31'b0, flag}), load, compare or live count in the next cycle with rd_valid high. Offsets 5 to 7 read 0 and ignore writes. A write to offset 4 has no effect.
- R2: A control write stores only bits 25:0. Bit 16 (soft reset) never reads back as 1, and bits 31:26 read 0.
- R3: Clock source field 25:24 selects the tick: 00 gives no ticks and freezes the count, 01 selects tick_periph, 10 selects tick_hf and 11 selects tick_slow.
- R4: With prescale field P, the count steps once for every P+1 selected ticks.
- R5: On a prescaled tick the count decrements. From zero it moves to the load value if bit 3 is set, otherwise to 0xFFFFFFFF.
- R6: The status flag sets when a prescaled tick moves the count to a value equal to compare while bit 2 is set.
- R7: irq equals flag AND bit 2 AND bit 0.
- R8: A status write with bit 0 set clears the flag, and a write with bit 0 clear has no effect. A flag set in the same cycle wins over the clear.
- R9: A control write with bit 16 set keeps only bits 0, 1, 18, 19, 20 and 21 of the written value. It also clears the flag, sets load to 0xFFFFFFFF, zeroes compare and the count, and restarts the prescaler phase.
- R10: A control write that takes bit 0 from 0 to 1 with bit 1 set reloads the count, from load if bit 3 is set and otherwise from 0xFFFFFFFF. With bit 1 clear, counting resumes from the held count.
- R11: A load write while bit 17 is set also overwrites the count. Without bit 17 the count is untouched until the next reload.
- R12: While bit 0 is clear the count and prescaler phase hold.
- R13: After reset, control, status, compare and count are 0, load is 0xFFFFFFFF and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_ready | output | 1 | Always high: request accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| tick_periph | input | 1 | Peripheral tick enable |
| tick_hf | input | 1 | High-frequency tick enable |
| tick_slow | input | 1 | Slow (32 kHz) tick enable |
| irq | output | 1 | Level compare interrupt |

## Verification
A register write takes effect at the clock edge that accepts it. A read response shows the register value from before that edge and appears one cycle later, so the bench checks rd_data at the falling edge after the request cycle. A prescaled tick updates the count and flag at the edge where the source tick is sampled, and irq follows combinationally from the flag, so both are checked at the next falling edge. The bench reference model advances at the same edges as the design and is compared at every falling edge, covering directed corner cases and a seeded random mix of ticks and accesses.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CTRL_W     = 26;
  localparam int B_RUN      = 0;
  localparam int B_RESTART  = 1;
  localparam int B_CMP_IE   = 2;
  localparam int B_USE_LOAD = 3;
  localparam int B_PSC_LO   = 4;
  localparam int B_PSC_HI   = 15;
  localparam int B_SOFT_RST = 16;
  localparam int B_LOAD_OW  = 17;
  localparam int B_SRC_LO   = 24;
  localparam int B_SRC_HI   = 25;

  // bits surviving a soft reset: run, restart-on-run, hold bits 21:18
  localparam logic [CTRL_W-1:0] KEEP_ON_SRST = 26'h03C_0003;
  // soft reset bit self-clears
  localparam logic [CTRL_W-1:0] CTRL_WR_MASK = 26'h3FE_FFFF;

  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_STAT = 3'd1,
    REG_LOAD = 3'd2,
    REG_CMP  = 3'd3,
    REG_CNT  = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic srst;
    logic restart;
    logic restart_use_load;
    logic force_ld;
  } cnt_cmd_t;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int NSRC  = 3,
  parameter int PSC_W = 12,
  localparam int SEL_W = $clog2(NSRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [NSRC-1:0]  src_ticks,
  input  logic [PSC_W-1:0] div,
  input  logic             sync_clr,
  output logic             tick_out
);
  logic [NSRC:0]    src_vec;
  logic             sel_tick;
  logic [PSC_W-1:0] phase;

  // selector value 0 maps to a constant-low source
  assign src_vec  = {src_ticks, 1'b0};
  assign sel_tick = src_vec[src_sel];
  assign tick_out = run && sel_tick && (phase == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               phase <= '0;
    else if (sync_clr)        phase <= '0;
    else if (run && sel_tick) phase <= tick_out ? '0 : phase + 1'b1;
  end

  // R12: phase frozen while stopped
  p_phase_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !sync_clr) |=> $stable(phase));
  // R4: a divided tick starts a fresh phase
  p_phase_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_out && !sync_clr) |=> (phase == '0));
endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         ptick,
  input  logic         use_load,
  input  logic         cmp_ie,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] cmp_val,
  input  logic [W-1:0] force_val,
  input  cnt_cmd_t     cmd,
  output logic [W-1:0] count,
  output logic         cmp_hit
);
  logic [W-1:0] next_dec;

  assign next_dec = (count == '0) ? (use_load ? load_val : '1) : count - 1'b1;
  assign cmp_hit  = ptick && cmp_ie && (next_dec == cmp_val);

  // priority: soft reset, restart, overwrite, tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            count <= '0;
    else if (cmd.srst)     count <= '0;
    else if (cmd.restart)  count <= cmd.restart_use_load ? load_val : '1;
    else if (cmd.force_ld) count <= force_val;
    else if (ptick)        count <= next_dec;
  end

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cmd.srst && !cmd.restart && !cmd.force_ld) |=> $stable(count));
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptick && count == '0 && !use_load && !cmd.srst && !cmd.force_ld) |=> (count == '1));
  p_restart_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.restart && !cmd.srst && !cmd.restart_use_load) |=> (count == '1));
  p_overwrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.force_ld && !cmd.srst && !cmd.restart) |=> (count == $past(force_val)));
endmodule

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              cmp_hit,
  input  logic [DATA_W-1:0] count_val,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [CTRL_W-1:0] ctrl,
  output logic              flag,
  output logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] cmp_val,
  output cnt_cmd_t          cmd
);
  logic wr, rd, wr_ctrl, wr_stat, wr_load, wr_cmp;
  logic [DATA_W-1:0] rd_mux;

  assign wr      = bus_valid && bus_write;
  assign rd      = bus_valid && !bus_write;
  assign wr_ctrl = wr && (bus_addr == ADDR_W'(REG_CTRL));
  assign wr_stat = wr && (bus_addr == ADDR_W'(REG_STAT));
  assign wr_load = wr && (bus_addr == ADDR_W'(REG_LOAD));
  assign wr_cmp  = wr && (bus_addr == ADDR_W'(REG_CMP));

  assign cmd.srst             = wr_ctrl && bus_wdata[B_SOFT_RST];
  assign cmd.restart          = wr_ctrl && !bus_wdata[B_SOFT_RST] && bus_wdata[B_RUN]
                                && bus_wdata[B_RESTART] && !ctrl[B_RUN];
  assign cmd.restart_use_load = bus_wdata[B_USE_LOAD];
  assign cmd.force_ld         = wr_load && ctrl[B_LOAD_OW];

  always_comb begin
    case (bus_addr)
      ADDR_W'(REG_CTRL): rd_mux = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
      ADDR_W'(REG_STAT): rd_mux = {{(DATA_W-1){1'b0}}, flag};
      ADDR_W'(REG_LOAD): rd_mux = load_val;
      ADDR_W'(REG_CMP):  rd_mux = cmp_val;
      ADDR_W'(REG_CNT):  rd_mux = count_val;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      flag     <= 1'b0;
      load_val <= '1;
      cmp_val  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (wr_ctrl)
        ctrl <= cmd.srst ? (bus_wdata[CTRL_W-1:0] & KEEP_ON_SRST)
                         : (bus_wdata[CTRL_W-1:0] & CTRL_WR_MASK);
      if (cmd.srst) begin
        flag     <= 1'b0;
        load_val <= '1;
        cmp_val  <= '0;
      end else begin
        if (cmp_hit)                       flag <= 1'b1;
        else if (wr_stat && bus_wdata[0])  flag <= 1'b0;
        if (wr_load) load_val <= bus_wdata;
        if (wr_cmp)  cmp_val  <= bus_wdata;
      end
      rd_valid <= rd;
      if (rd) rd_data <= rd_mux;
    end
  end

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && !cmd.srst) |=> flag);
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[0] && !cmp_hit) |=> !flag);
  p_flag_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !cmd.srst && !(wr_stat && bus_wdata[0])) |=> flag);
  p_srst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.srst |=> (load_val == '1 && cmp_val == '0 && !flag && !ctrl[B_SOFT_RST]));
  p_rd_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rd_valid);
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int NSRC   = 3,
  localparam int PSC_W = B_PSC_HI - B_PSC_LO + 1,
  localparam int SEL_W = B_SRC_HI - B_SRC_LO + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tick_periph,
  input  logic              tick_hf,
  input  logic              tick_slow,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrl;
  logic              flag, cmp_hit, ptick;
  logic [DATA_W-1:0] load_val, cmp_val, count;
  cnt_cmd_t          cmd;

  assign bus_ready = 1'b1;

  pit_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cmp_hit(cmp_hit),
    .count_val(count), .rd_valid(rd_valid), .rd_data(rd_data), .ctrl(ctrl),
    .flag(flag), .load_val(load_val), .cmp_val(cmp_val), .cmd(cmd)
  );

  pit_prescaler #(.NSRC(NSRC), .PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(ctrl[B_RUN]),
    .src_sel(ctrl[B_SRC_HI:B_SRC_LO]),
    .src_ticks({tick_slow, tick_hf, tick_periph}),
    .div(ctrl[B_PSC_HI:B_PSC_LO]), .sync_clr(cmd.srst | cmd.restart),
    .tick_out(ptick)
  );

  pit_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl[B_RUN]), .ptick(ptick),
    .use_load(ctrl[B_USE_LOAD]), .cmp_ie(ctrl[B_CMP_IE]),
    .load_val(load_val), .cmp_val(cmp_val), .force_val(bus_wdata),
    .cmd(cmd), .count(count), .cmp_hit(cmp_hit)
  );

  assign irq = flag && ctrl[B_CMP_IE] && ctrl[B_RUN];

  // R7: interrupt never raised without a pending flag
  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
  // R3: with no source selected the divided tick never fires
  p_no_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[B_SRC_HI:B_SRC_LO] == '0) |-> !ptick);
endmodule

// File: tb/tb_pit_timer.sv
module tb_pit_timer;
  localparam time TCK = 20ns;
  logic clk = 1'b0, rst_n = 1'b0;
  always #(TCK/2) clk = ~clk;

  logic bus_valid = 0, bus_write = 0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic tick_periph = 0, tick_hf = 0, tick_slow = 0;
  logic bus_ready, rd_valid, irq;
  logic [31:0] rd_data;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  pit_timer dut (.*);

  // reference model from the requirements
  logic [25:0] m_ctrl;
  logic        m_flag;
  logic [31:0] m_load, m_cmp, m_cnt, m_rd;
  logic [11:0] m_pc;

  always @(posedge clk) begin
    logic src, pt, setf;
    logic [31:0] nxt;
    if (!rst_n) begin
      m_ctrl = '0; m_flag = 0; m_load = '1; m_cmp = '0; m_cnt = '0; m_pc = '0; m_rd = '0;
    end else begin
      if (bus_valid && !bus_write)
        case (bus_addr)
          3'd0: m_rd = {6'b0, m_ctrl};
          3'd1: m_rd = {31'b0, m_flag};
          3'd2: m_rd = m_load;
          3'd3: m_rd = m_cmp;
          3'd4: m_rd = m_cnt;
          default: m_rd = '0;
        endcase
      case (m_ctrl[25:24])
        2'd0: src = 0;
        2'd1: src = tick_periph;
        2'd2: src = tick_hf;
        default: src = tick_slow;
      endcase
      pt = m_ctrl[0] && src && (m_pc == m_ctrl[15:4]);
      setf = 0;
      nxt = (m_cnt == 0) ? (m_ctrl[3] ? m_load : 32'hFFFF_FFFF) : m_cnt - 1;
      if (m_ctrl[0] && src) m_pc = pt ? 12'd0 : m_pc + 12'd1;
      if (pt) begin
        if (m_ctrl[2] && nxt == m_cmp) setf = 1;
        m_cnt = nxt;
      end
      if (setf) m_flag = 1;
      if (bus_valid && bus_write)
        case (bus_addr)
          3'd0: if (bus_wdata[16]) begin
                  m_ctrl = bus_wdata[25:0] & 26'h03C_0003;
                  m_flag = 0; m_load = '1; m_cmp = '0; m_cnt = '0; m_pc = '0;
                end else begin
                  if (bus_wdata[0] && bus_wdata[1] && !m_ctrl[0]) begin
                    m_cnt = bus_wdata[3] ? m_load : 32'hFFFF_FFFF;
                    m_pc = '0;
                  end
                  m_ctrl = bus_wdata[25:0] & ~26'h001_0000;
                end
          3'd1: if (bus_wdata[0] && !setf) m_flag = 0;
          3'd2: begin if (m_ctrl[17]) m_cnt = bus_wdata; m_load = bus_wdata; end
          3'd3: m_cmp = bus_wdata;
          default: ;
        endcase
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    @(negedge clk); bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk); bus_valid = 0;
    chk({tag, " rd_valid"}, {31'b0, rd_valid}, 32'd1);
    chk(tag, rd_data, m_rd);
  endtask

  task automatic rdx(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk); bus_valid = 0;
    chk(tag, rd_data, exp);
  endtask

  task automatic pulse(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_periph = (which == 1); tick_hf = (which == 2); tick_slow = (which == 3);
    end
    @(negedge clk); tick_periph = 0; tick_hf = 0; tick_slow = 0;
  endtask

  task automatic chk_irq(string tag);
    chk(tag, {31'b0, irq}, {31'b0, m_flag && m_ctrl[2] && m_ctrl[0]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R13 reset state
    chk("R13 irq", {31'b0, irq}, 32'd0);
    rdx(3'd0, 32'h0, "R13 ctrl");
    rdx(3'd1, 32'h0, "R13 status");
    rdx(3'd2, 32'hFFFF_FFFF, "R13 load");
    rdx(3'd3, 32'h0, "R13 compare");
    rdx(3'd4, 32'h0, "R13 count");
    // R2 width mask
    wr(3'd0, 32'hFFFE_FFFE);
    rdx(3'd0, 32'h03FE_FFFE, "R2 ctrl mask");
    wr(3'd0, 32'h0);
    // R1 undefined offsets and read-only count
    wr(3'd6, 32'h1234_5678);
    rdx(3'd6, 32'h0, "R1 undefined read");
    rd(3'd2, "R1 load after bad write");
    wr(3'd4, 32'h5);
    rdx(3'd4, 32'h0, "R1 count read-only");
    // R10 restart from load, R3/R5 count down
    wr(3'd2, 32'd10);
    wr(3'd0, 32'h0100_000B);
    rdx(3'd4, 32'd10, "R10 restart from load");
    pulse(1, 3);
    rdx(3'd4, 32'd7, "R5 decrement");
    pulse(2, 4);
    rdx(3'd4, 32'd7, "R3 other source ignored");
    // R4 prescale 2
    wr(3'd0, 32'h0100_002B);
    pulse(1, 6);
    rdx(3'd4, 32'd5, "R4 divide by three");
    pulse(1, 18);
    rdx(3'd4, 32'd10, "R5 reload from load");
    // R6/R7 compare
    wr(3'd3, 32'd8);
    wr(3'd0, 32'h0100_002F);
    pulse(1, 6);
    rdx(3'd1, 32'd1, "R6 flag set");
    chk("R7 irq high", {31'b0, irq}, 32'd1);
    // R8 clear
    wr(3'd1, 32'h0);
    rdx(3'd1, 32'd1, "R8 zero write no effect");
    wr(3'd1, 32'h1);
    rdx(3'd1, 32'd0, "R8 flag cleared");
    chk("R7 irq low", {31'b0, irq}, 32'd0);
    // R7 gating by interrupt enable
    wr(3'd3, 32'd7);
    pulse(1, 3);
    wr(3'd0, 32'h0100_002B);
    chk("R7 gated by enable", {31'b0, irq}, 32'd0);
    rd(3'd1, "R7 flag kept");
    wr(3'd0, 32'h0100_002F);
    chk_irq("R7 re-enabled");
    wr(3'd1, 32'h1);
    // R12 stop holds
    wr(3'd0, 32'h0100_002A);
    rd(3'd4, "R12 before stop ticks");
    pulse(1, 9);
    rd(3'd4, "R12 held");
    // R11 overwrite
    wr(3'd0, 32'h0102_002A);
    wr(3'd2, 32'h100);
    rdx(3'd4, 32'h100, "R11 overwrite");
    wr(3'd0, 32'h0100_002A);
    wr(3'd2, 32'h50);
    rdx(3'd4, 32'h100, "R11 no overwrite");
    wr(3'd0, 32'h0100_0029);
    pulse(1, 3);
    rdx(3'd4, 32'hFF, "R10 resume held value");
    // R5 free wrap
    wr(3'd0, 32'h0102_0020);
    wr(3'd2, 32'h0);
    wr(3'd0, 32'h0100_0001);
    pulse(1, 1);
    rdx(3'd4, 32'hFFFF_FFFF, "R5 wrap to all ones");
    // R10 restart to all ones
    wr(3'd0, 32'h0100_0000);
    wr(3'd0, 32'h0100_0003);
    rdx(3'd4, 32'hFFFF_FFFF, "R10 restart all ones");
    // R9 soft reset
    wr(3'd3, 32'd3);
    wr(3'd0, 32'h03FF_FFFF);
    rdx(3'd0, 32'h003C_0003, "R9 ctrl kept bits");
    rdx(3'd2, 32'hFFFF_FFFF, "R9 load");
    rdx(3'd3, 32'h0, "R9 compare");
    rdx(3'd4, 32'h0, "R9 count");
    rdx(3'd1, 32'h0, "R9 status");
    pulse(1, 4); pulse(3, 4);
    rdx(3'd4, 32'h0, "R3 source none frozen");
    wr(3'd0, 32'h0);

    // random mix
    void'($urandom(32'd20240607));
    for (int i = 0; i < 6000; i++) begin
      int op;
      @(negedge clk);
      if (rd_valid) chk("R1 random read", rd_data, m_rd);
      chk_irq("R7 random irq");
      tick_periph = $urandom % 2; tick_hf = $urandom % 2; tick_slow = $urandom % 2;
      op = $urandom % 16;
      bus_valid = 0; bus_write = 0;
      case (op)
        0: begin
             bus_valid = 1; bus_write = 1; bus_addr = 3'd0;
             bus_wdata = $urandom & 32'h0302_002F;
             if ($urandom % 24 == 0) bus_wdata[16] = 1;
           end
        1: begin bus_valid = 1; bus_write = 1; bus_addr = 3'd2; bus_wdata = $urandom % 48; end
        2: begin bus_valid = 1; bus_write = 1; bus_addr = 3'd3; bus_wdata = $urandom % 48; end
        3: begin bus_valid = 1; bus_write = 1; bus_addr = 3'd1; bus_wdata = $urandom % 2; end
        4, 5, 6, 7: begin bus_valid = 1; bus_addr = 3'($urandom); end
        default: ;
      endcase
    end
    @(negedge clk);
    bus_valid = 0;
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(TCK * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule